// File: doc/BRIEF.md
# Frame Word Splitter with Status Trailer

This block sits after a 10 Gb Ethernet receive MAC and feeds a 32-bit AXI4-Stream consumer such as an embedded processor. On each clock the MAC may present a beat made of a 64-bit word and three flags: data-valid, end-of-good-frame and end-of-bad-frame. A beat is taken when any of the three flags is high and the block has room. Taken beats wait in a small buffer.

For every word that carries data, the block sends two 32-bit beats, the upper half of the word first. When a beat closes a frame, the block then sends one status beat that tells the consumer whether the frame was good or bad. The status beat is the only beat with TLAST, so the consumer sees one packet per frame that ends in a verdict word. A closing beat may arrive with data-valid low. Such a beat produces only the status beat.

The stream side follows AXI4-Stream rules. TVALID and the payload stay fixed while TREADY is low. When the buffer is full, the input side is held off through a ready output.

Top module: `frame_word_splitter`

## Requirements
- R1: An input beat is stored only when `inReady` is high and at least one of `inValid`, `inEndGood`, `inEndBad` is high. A beat with all three low produces no output beat.
- R2: A stored beat with `inValid` high produces two stream beats, `inData[63:32]` first and then `inData[31:0]`.
- R3: A stored beat with `inEndGood` or `inEndBad` high is followed, after its data beats if any, by exactly one status beat. In that beat bit 0 equals the good flag, bit 1 equals the bad flag, and bits 31:2 are zero.
- R4: `streamLast` is high on the status beat and low on every data beat.
- R5: `streamKeep` is 4'b1111 on every beat, including the status beat.
- R6: A stored beat with `inValid` low and an end flag high produces only its status beat and no data beats.
- R7: While `streamValid` is high and `streamReady` is low, `streamValid` stays high and `streamData` and `streamLast` do not change on the next cycle.
- R8: The buffer holds DEPTH beats. With the stream stalled, exactly DEPTH beats are taken, `inReady` then stays low, and the beats offered while it is low are not stored.
- R9: During and after reset, `streamValid` is low and `inReady` is high. After reset the first data beat of a new word is its upper half, and no beat from before the reset is sent.
- R10: Beats come out in the order they were taken, across frame boundaries and under any pattern of `streamReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | The beat carries a data word |
| inData | input | 64 | Received data word |
| inEndGood | input | 1 | The beat closes a frame that passed the MAC's checks |
| inEndBad | input | 1 | The beat closes a frame that failed the MAC's checks |
| inReady | output | 1 | The buffer can take a beat this cycle |
| streamValid | output | 1 | Stream beat available |
| streamData | output | 32 | Stream payload: a half word or the status word |
| streamKeep | output | 4 | Byte qualifiers, always all ones |
| streamLast | output | 1 | Marks the status beat that closes a frame |
| streamReady | input | 1 | The consumer accepts the beat |

## Verification
The bench builds the block with its defaults: a 64-bit input word and a four-entry buffer. With only four entries, a stalled consumer fills the buffer within four input cycles. That makes the full-buffer refusal and the long hold of a stalled beat quick to reach, while the same stimulus table also runs under a throttled `streamReady`. The table also contains data-less closing beats, beats with both end flags set, and beats with no flags at all. A reset issued while beats are still buffered shows that none of them leaks out afterwards.

// File: rtl/fws_pkg.sv
package fws_pkg;

  // which slice of the buffered beat drives the stream payload
  typedef enum logic [1:0] {
    LANE_HIGH  = 2'd0,
    LANE_LOW   = 2'd1,
    LANE_TRAIL = 2'd2
  } laneSel_e;

  // emission phase of the control FSM
  typedef enum logic [1:0] {
    PH_HIGH  = 2'd0,
    PH_LOW   = 2'd1,
    PH_TRAIL = 2'd2
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     pop;
    laneSel_e lane;
  } dpStrobe_t;

endpackage

// File: rtl/fws_beat_buffer.sv
module fws_beat_buffer #(
  parameter int W     = 67,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic         full,
  output logic         empty,
  output logic [W-1:0] headData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (push) slots[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST_SLOT) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST_SLOT) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full     = (count == FULL_CNT);
  assign empty    = (count == '0);
  assign headData = slots[rdPtr];

  // R8: writer never pushes into a full buffer
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !full);

  // R10: control never retires a beat that is not there
  a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty);

endmodule

// File: rtl/fws_datapath.sv
module fws_datapath
  import fws_pkg::*;
#(
  parameter int IN_W  = 64,
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [IN_W-1:0]   inData,
  input  logic              inEndGood,
  input  logic              inEndBad,
  output logic              inReady,
  input  dpStrobe_t         strobe,
  output logic              headPresent,
  output logic              headHasData,
  output logic              headEnds,
  output logic [IN_W/2-1:0] outData
);
  localparam int OUT_W   = IN_W / 2;
  localparam int ENTRY_W = IN_W + 3;

  logic               full, empty, push;
  logic [ENTRY_W-1:0] entryIn, entryHead;
  logic [IN_W-1:0]    headWord;
  logic               headGood, headBad;

  // entry layout: {bad, good, dataValid, word}
  assign entryIn = {inEndBad, inEndGood, inValid, inData};
  assign inReady = !full;
  assign push    = (inValid || inEndGood || inEndBad) && !full;

  fws_beat_buffer #(.W(ENTRY_W), .DEPTH(DEPTH)) u_buffer (
    .clk      (clk),
    .rstN     (rstN),
    .push     (push),
    .pushData (entryIn),
    .pop      (strobe.pop),
    .full     (full),
    .empty    (empty),
    .headData (entryHead)
  );

  assign headWord    = entryHead[IN_W-1:0];
  assign headHasData = entryHead[IN_W];
  assign headGood    = entryHead[IN_W+1];
  assign headBad     = entryHead[IN_W+2];
  assign headPresent = !empty;
  assign headEnds    = headGood || headBad;

  always_comb begin
    unique case (strobe.lane)
      LANE_HIGH:  outData = headWord[IN_W-1:OUT_W];
      LANE_LOW:   outData = headWord[OUT_W-1:0];
      LANE_TRAIL: outData = {{(OUT_W-2){1'b0}}, headBad, headGood};
      default:    outData = '0;
    endcase
  end

  // R3: status lane is only selected for a present beat that closed a frame
  a_r3_trailer_has_flag: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lane == LANE_TRAIL && strobe.pop) |-> (!empty && outData[1:0] != 2'b00));

endmodule

// File: rtl/fws_ctrl.sv
module fws_ctrl
  import fws_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      headPresent,
  input  logic      headHasData,
  input  logic      headEnds,
  input  logic      outReady,
  output logic      outValid,
  output logic      outLast,
  output dpStrobe_t strobe
);
  phase_e phase, phaseNext;
  logic   fire;

  always_comb begin
    phaseNext   = phase;
    strobe.pop  = 1'b0;
    strobe.lane = LANE_HIGH;
    outValid    = 1'b0;
    outLast     = 1'b0;
    unique case (phase)
      PH_HIGH: begin
        strobe.lane = LANE_HIGH;
        outValid    = headPresent && headHasData;
      end
      PH_LOW: begin
        strobe.lane = LANE_LOW;
        outValid    = headPresent;
      end
      PH_TRAIL: begin
        strobe.lane = LANE_TRAIL;
        outValid    = headPresent;
        outLast     = headPresent;
      end
      default: ;
    endcase
    fire = outValid && outReady;
    unique case (phase)
      PH_HIGH: begin
        if (headPresent && !headHasData) phaseNext = PH_TRAIL;
        else if (fire)                   phaseNext = PH_LOW;
      end
      PH_LOW: begin
        if (fire) begin
          phaseNext  = headEnds ? PH_TRAIL : PH_HIGH;
          strobe.pop = !headEnds;
        end
      end
      PH_TRAIL: begin
        if (fire) begin
          phaseNext  = PH_HIGH;
          strobe.pop = 1'b1;
        end
      end
      default: phaseNext = PH_HIGH;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_HIGH;
    else       phase <= phaseNext;
  end

  // R4: a last marker is only raised for a beat that closed a frame
  a_r4_last_needs_end: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> headEnds);

  // R10: a beat is retired only on a completed handshake
  a_r10_pop_on_fire: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> (outValid && outReady));

  // R2: after the upper half is taken, the lower half of the same word follows
  a_r2_low_after_high: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HIGH && outValid && outReady) |=> (outValid && !outLast && !strobe.pop || phase == PH_LOW));

endmodule

// File: rtl/frame_word_splitter.sv
module frame_word_splitter
  import fws_pkg::*;
#(
  parameter int IN_W  = 64,
  parameter int DEPTH = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [IN_W-1:0]     inData,
  input  logic                inEndGood,
  input  logic                inEndBad,
  output logic                inReady,
  output logic                streamValid,
  output logic [IN_W/2-1:0]   streamData,
  output logic [IN_W/16-1:0]  streamKeep,
  output logic                streamLast,
  input  logic                streamReady
);
  localparam int OUT_W  = IN_W / 2;
  localparam int KEEP_W = OUT_W / 8;

  dpStrobe_t strobe;
  logic      headPresent, headHasData, headEnds;

  fws_datapath #(.IN_W(IN_W), .DEPTH(DEPTH)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .inData      (inData),
    .inEndGood   (inEndGood),
    .inEndBad    (inEndBad),
    .inReady     (inReady),
    .strobe      (strobe),
    .headPresent (headPresent),
    .headHasData (headHasData),
    .headEnds    (headEnds),
    .outData     (streamData)
  );

  fws_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .headPresent (headPresent),
    .headHasData (headHasData),
    .headEnds    (headEnds),
    .outReady    (streamReady),
    .outValid    (streamValid),
    .outLast     (streamLast),
    .strobe      (strobe)
  );

  assign streamKeep = {KEEP_W{1'b1}};

  // R7: a stalled beat is held unchanged
  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    (streamValid && !streamReady) |=> (streamValid && $stable(streamData) && $stable(streamLast)));

  // R3: upper bits of the status beat are zero
  a_r3_status_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (streamValid && streamLast) |-> (streamData[OUT_W-1:2] == '0));

endmodule

// File: tb/frame_word_splitter_bench.sv
module frame_word_splitter_bench;
  localparam int IN_W  = 64;
  localparam int DEPTH = 4;
  localparam int NVEC  = 11;
  localparam int MAXEXP = 1024;

  // {dataValid, endGood, endBad, word}
  localparam logic [66:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b0, 64'h1111_2222_3333_4444},
    {1'b1, 1'b1, 1'b0, 64'hA5A5_0F0F_DEAD_BEEF},
    {1'b1, 1'b0, 1'b1, 64'h0123_4567_89AB_CDEF},
    {1'b0, 1'b1, 1'b0, 64'hFFFF_0000_FFFF_0000},
    {1'b0, 1'b0, 1'b0, 64'h5555_5555_5555_5555},
    {1'b1, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_0001},
    {1'b1, 1'b1, 1'b1, 64'h8000_0000_7FFF_FFFF},
    {1'b0, 1'b0, 1'b1, 64'h0000_0000_0000_0000},
    {1'b1, 1'b1, 1'b0, 64'h0000_0000_0000_0000},
    {1'b0, 1'b0, 1'b0, 64'hDEAD_DEAD_DEAD_DEAD}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid, inEndGood, inEndBad, inReady;
  logic [63:0] inData;
  logic        streamValid, streamLast, streamReady;
  logic [31:0] streamData;
  logic [3:0]  streamKeep;

  always #4 clk = ~clk;

  frame_word_splitter #(.IN_W(IN_W), .DEPTH(DEPTH)) u_frame_word_splitter (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .inData      (inData),
    .inEndGood   (inEndGood),
    .inEndBad    (inEndBad),
    .inReady     (inReady),
    .streamValid (streamValid),
    .streamData  (streamData),
    .streamKeep  (streamKeep),
    .streamLast  (streamLast),
    .streamReady (streamReady)
  );

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;
  logic [31:0] expData [MAXEXP];
  logic        expLast [MAXEXP];
  int wrIdx = 0;
  int rdIdx = 0;
  bit monOn = 1'b0;
  int readyMode = 0;
  bit prevStall = 1'b0;
  logic [31:0] prevData;
  logic        prevLast;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic addExp(input logic [31:0] d, input logic l);
    expData[wrIdx] = d;
    expLast[wrIdx] = l;
    wrIdx++;
  endtask

  // expected stream per R2, R3, R6
  task automatic modelBeat(input logic v, input logic g, input logic b, input logic [63:0] d);
    if (v) begin
      addExp(d[63:32], 1'b0);
      addExp(d[31:0], 1'b0);
    end
    if (g || b) addExp({30'b0, b, g}, 1'b1);
  endtask

  // caller sits just after a rising edge
  task automatic sendBeat(input logic [66:0] vec);
    inValid   = vec[66];
    inEndGood = vec[65];
    inEndBad  = vec[64];
    inData    = vec[63:0];
    if (!(vec[66] || vec[65] || vec[64])) begin
      @(posedge clk); #1;   // R1: no flag, nothing expected
    end else begin
      forever begin
        @(negedge clk);
        if (inReady) break;
      end
      modelBeat(vec[66], vec[65], vec[64], vec[63:0]);
      @(posedge clk); #1;
    end
    inValid = 1'b0; inEndGood = 1'b0; inEndBad = 1'b0;
  endtask

  task automatic drainAndCheck(input string tag);
    int n = 0;
    while (rdIdx != wrIdx && n < 400) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
    // R1 / R10: every expected beat seen, nothing extra pending
    chk(rdIdx == wrIdx && !streamValid, tag, 64'(rdIdx), 64'(wrIdx));
    @(posedge clk); #1;
  endtask

  // consumer ready pattern
  initial begin
    streamReady = 1'b1;
    forever begin
      @(posedge clk); #1;
      case (readyMode)
        0: streamReady = 1'b1;
        1: streamReady = (cycles % 3) != 0;
        default: streamReady = 1'b0;
      endcase
    end
  end

  // stream monitor
  always @(negedge clk) begin
    if (!monOn) begin
      prevStall = 1'b0;
    end else begin
      if (prevStall)
        chk(streamValid && streamData == prevData && streamLast == prevLast,
            "R7 stall hold", {31'b0, streamValid, streamData}, {32'b1, prevData});
      if (streamValid && streamReady) begin
        if (rdIdx >= wrIdx) begin
          chk(1'b0, "R1 unexpected beat", {32'b0, streamData}, 64'b0);
        end else begin
          chk(streamData == expData[rdIdx], "R2 R3 R6 R10 data", {32'b0, streamData}, {32'b0, expData[rdIdx]});
          chk(streamLast == expLast[rdIdx], "R4 last", {63'b0, streamLast}, {63'b0, expLast[rdIdx]});
          chk(streamKeep == 4'hF, "R5 keep", {60'b0, streamKeep}, 64'hF);
          rdIdx++;
        end
      end
      prevStall = streamValid && !streamReady;
      prevData  = streamData;
      prevLast  = streamLast;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nFail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int accepted;
    rstN = 1'b0;
    inValid = 1'b0; inEndGood = 1'b0; inEndBad = 1'b0; inData = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!streamValid && inReady && !streamLast, "R9 reset state",
        {61'b0, streamValid, inReady, streamLast}, 64'b010);
    @(posedge clk); #1;
    rstN = 1'b1;
    monOn = 1'b1;

    // table walk, consumer always ready
    readyMode = 0;
    for (int i = 0; i < NVEC; i++) sendBeat(VEC[i]);
    drainAndCheck("R1 drain open");

    // same table under throttled ready (R7, R10)
    readyMode = 1;
    for (int i = 0; i < NVEC; i++) sendBeat(VEC[i]);
    drainAndCheck("R10 drain throttled");

    // R8: fill buffer against a stalled consumer
    readyMode = 2;
    @(posedge clk); #1;
    accepted = 0;
    inValid = 1'b1;
    for (int k = 0; k < DEPTH + 4; k++) begin
      inData = {32'hC0DE_0000 + 32'(k), 32'h0BAD_0000 + 32'(k)};
      @(negedge clk);
      if (inReady) begin
        accepted++;
        modelBeat(1'b1, 1'b0, 1'b0, inData);
      end
      @(posedge clk); #1;
    end
    inValid = 1'b0;
    @(negedge clk);
    chk(accepted == DEPTH, "R8 accepted count", 64'(accepted), 64'(DEPTH));
    chk(!inReady, "R8 ready low when full", {63'b0, inReady}, 64'b0);
    chk(streamValid && streamData == 32'hC0DE_0000, "R8 R2 head upper half",
        {32'b0, streamData}, 64'hC0DE_0000);
    @(posedge clk); #1;
    readyMode = 0;
    sendBeat({1'b0, 1'b1, 1'b0, 64'h0});
    drainAndCheck("R8 drain after fill");

    // R9: reset with beats still buffered
    readyMode = 2;
    sendBeat({1'b1, 1'b0, 1'b0, 64'h7777_6666_5555_4444});
    sendBeat({1'b0, 1'b0, 1'b1, 64'h0});
    repeat (2) @(posedge clk);
    #1;
    monOn = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    chk(!streamValid && inReady, "R9 mid-run reset",
        {62'b0, streamValid, inReady}, 64'b01);
    @(posedge clk); #1;
    rstN = 1'b1;
    wrIdx = 0;
    rdIdx = 0;
    monOn = 1'b1;
    readyMode = 0;
    sendBeat({1'b1, 1'b1, 1'b0, 64'h9999_AAAA_BBBB_CCCC});
    drainAndCheck("R9 drain after reset");

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule